// File: doc/BRIEF.md
# Watchdog Timer with Dual-Clear Option

This block is the watchdog counter of a small microcontroller core. It counts ticks from one of two sources and raises a reset request when software fails to service it in time. A static option picks the source: a tick from a dedicated low-speed oscillator, or the instruction clock, which is one tick every four system clocks. A second static option picks the time-out length. The count is `2^SHORT_LOG2` ticks or `2^LONG_LOG2` ticks, which by default is 32768 or 65536.

Software services the counter with clear-instruction strobes. A static option selects single-clear or dual-clear operation. In dual-clear operation two different clear strobes must both be seen before the count restarts. The halt instruction and the synchronous reset also restart the count. The block keeps two status flags. The time-out flag records that a time-out has happened. The power-down flag records that the halt instruction has run.

When a time-out occurs during normal running, the block requests a full chip reset. When it occurs while the core is halted, the block requests a warm reset, which restarts only the program counter and stack pointer. Both requests are single-cycle pulses. A disable option makes the whole watchdog inert.

Top module: `wdt_core`

## Requirements
- R1: While `rst` is high, the count, the prescaler, the pending half-clear state and both flags are cleared, and both request outputs are low. After `rst` falls, a full period of ticks is needed before a time-out.
- R2: With `opt_src_rc`=1, each cycle in which `rc_tick` is high counts one tick. With `opt_src_rc`=0, `rc_tick` is ignored and one tick is counted every 4 clocks. The first of these ticks comes on the 4th clock edge after a count clear.
- R3: A time-out occurs on the edge of the `2^SHORT_LOG2`-th tick after the last clear when `opt_long`=0, and on the `2^LONG_LOG2`-th tick when `opt_long`=1. The request output is high for exactly the one cycle after that edge. The count then restarts from zero.
- R4: A time-out with `halted`=0 pulses `chip_rst_req`. A time-out with `halted`=1 pulses `warm_rst_req`. The two outputs are never high together.
- R5: `to_flag` is set by every time-out. It is cleared by reset, by an effective software clear and by `halt_strobe`.
- R6: `pdf_flag` is set by `halt_strobe` and cleared by reset and by an effective software clear. If both arrive in the same cycle, the halt wins.
- R7: With `opt_dual`=0, a `clr_strobe` clears the count. `clr_a_strobe` and `clr_b_strobe` have no effect.
- R8: With `opt_dual`=1, the count is cleared only once both `clr_a_strobe` and `clr_b_strobe` have been seen. They may come in either order or in the same cycle. Either one alone has no effect, and `clr_strobe` has no effect.
- R9: A half-completed dual clear is forgotten whenever the count is cleared for any reason (a completed clear, a halt, a time-out or a reset). A later single strobe of the other kind then does not clear the count.
- R10: `halt_strobe` clears the count and the prescaler.
- R11: With `opt_src_rc`=0 and `halted`=1, no ticks are counted.
- R12: With `opt_enable`=0, the count is held at zero and no request is raised. Clear strobes leave the flags unchanged. `halt_strobe` still sets `pdf_flag` and clears `to_flag`.
- R13: A clear and a tick in the same cycle leave the count at zero, so no time-out occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up or external reset) |
| opt_enable | input | 1 | Static option: 1 enables the watchdog |
| opt_src_rc | input | 1 | Static option: 1 counts `rc_tick`, 0 counts the instruction clock (clk/4) |
| opt_long | input | 1 | Static option: 1 selects the `2^LONG_LOG2` period, 0 selects `2^SHORT_LOG2` |
| opt_dual | input | 1 | Static option: 1 requires both clear strobes |
| rc_tick | input | 1 | One-cycle tick from the low-speed oscillator, already synchronised |
| halted | input | 1 | Core is in the halt state |
| clr_strobe | input | 1 | Clear instruction executed (single-clear mode) |
| clr_a_strobe | input | 1 | First clear instruction of the pair executed |
| clr_b_strobe | input | 1 | Second clear instruction of the pair executed |
| halt_strobe | input | 1 | Halt instruction executed |
| chip_rst_req | output | 1 | One-cycle full chip reset request |
| warm_rst_req | output | 1 | One-cycle warm reset request (program counter and stack pointer) |
| to_flag | output | 1 | Time-out status flag |
| pdf_flag | output | 1 | Power-down status flag |

## Verification
The hardest case to reach from the ports is a stale half-clear. One dual-clear strobe is left pending, and then something other than its partner clears the count: a halt, a time-out or a completed pair. The stimulus first creates that state. It then issues only the partner strobe and counts ticks up to an exact edge, to show that the partner alone does not restart the count. The instruction-clock freeze during halt is reached the same way. A clear puts the prescaler at a known phase, and the run then predicts the exact edge on which the request appears after `halted` falls.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Instruction clock is the system clock divided by this ratio
    localparam int unsigned INSTR_DIV = 4;

    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_CHIP = 2'd1,
        REQ_WARM = 2'd2
    } wdt_req_e;

    typedef struct packed {
        logic enable;
        logic src_rc;
        logic long_sel;
        logic dual;
    } wdt_opt_t;

    // Highest count value before wrap for a period of 2^lg ticks
    function automatic logic [31:0] last_tick(input int unsigned lg);
        return (32'd1 << lg) - 32'd1;
    endfunction

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
    parameter int unsigned PRE_DIV = wdt_pkg::INSTR_DIV
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic src_rc,
    input  logic rc_tick,
    input  logic halted,
    input  logic clr,
    output logic tick
);
    localparam int unsigned PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);

    logic [PW-1:0] pre_q;
    logic          instr_run;

    // Instruction clock stops while the core is halted
    assign instr_run = enable & ~src_rc & ~halted;

    always_ff @(posedge clk) begin
        if (rst || clr || !enable) begin
            pre_q <= '0;
        end else if (instr_run) begin
            pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
        end
    end

    assign tick = enable & (src_rc ? rc_tick : (instr_run & (pre_q == PRE_LAST)));

endmodule

// File: rtl/wdt_clear_ctl.sv
module wdt_clear_ctl (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic dual,
    input  logic clr_single,
    input  logic clr_a,
    input  logic clr_b,
    input  logic halt_strobe,
    input  logic timeout,
    output logic sw_clr,
    output logic count_clr
);
    logic seen_a_q, seen_b_q;
    logic got_a, got_b;

    assign got_a = seen_a_q | clr_a;
    assign got_b = seen_b_q | clr_b;

    assign sw_clr    = enable & (dual ? (got_a & got_b) : clr_single);
    assign count_clr = sw_clr | (enable & halt_strobe);

    // Half-cleared memory, dropped on any count restart
    always_ff @(posedge clk) begin
        if (rst || count_clr || timeout || !enable || !dual) begin
            seen_a_q <= 1'b0;
            seen_b_q <= 1'b0;
        end else begin
            seen_a_q <= got_a;
            seen_b_q <= got_b;
        end
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int unsigned SHORT_LOG2 = 15,
    parameter int unsigned LONG_LOG2  = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic long_sel,
    input  logic tick,
    input  logic clr,
    output logic timeout
);
    localparam int unsigned CW = LONG_LOG2;
    localparam logic [CW-1:0] LAST_S = CW'(wdt_pkg::last_tick(SHORT_LOG2));
    localparam logic [CW-1:0] LAST_L = CW'(wdt_pkg::last_tick(LONG_LOG2));

    logic [CW-1:0] cnt_q;
    logic          at_last;

    assign at_last = (cnt_q == (long_sel ? LAST_L : LAST_S));
    assign timeout = enable & tick & at_last & ~clr;

    always_ff @(posedge clk) begin
        if (rst || clr || !enable) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_status.sv
module wdt_status
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic timeout,
    input  logic halted,
    input  logic sw_clr,
    input  logic halt_strobe,
    output logic chip_req,
    output logic warm_req,
    output logic to_flag,
    output logic pdf_flag
);
    wdt_req_e req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q    <= REQ_NONE;
            to_flag  <= 1'b0;
            pdf_flag <= 1'b0;
        end else begin
            req_q <= !timeout ? REQ_NONE : (halted ? REQ_WARM : REQ_CHIP);

            if (halt_strobe || sw_clr) to_flag <= 1'b0;
            else if (timeout)          to_flag <= 1'b1;

            if (halt_strobe)  pdf_flag <= 1'b1;
            else if (sw_clr)  pdf_flag <= 1'b0;
        end
    end

    assign chip_req = (req_q == REQ_CHIP);
    assign warm_req = (req_q == REQ_WARM);

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int unsigned SHORT_LOG2 = 15,
    parameter int unsigned LONG_LOG2  = 16,
    parameter int unsigned PRE_DIV    = INSTR_DIV
) (
    input  logic clk,
    input  logic rst,
    input  logic opt_enable,
    input  logic opt_src_rc,
    input  logic opt_long,
    input  logic opt_dual,
    input  logic rc_tick,
    input  logic halted,
    input  logic clr_strobe,
    input  logic clr_a_strobe,
    input  logic clr_b_strobe,
    input  logic halt_strobe,
    output logic chip_rst_req,
    output logic warm_rst_req,
    output logic to_flag,
    output logic pdf_flag
);
    wdt_opt_t opt;
    logic     tick, timeout, sw_clr, count_clr;

    assign opt = '{enable: opt_enable, src_rc: opt_src_rc,
                   long_sel: opt_long, dual: opt_dual};

    wdt_tick_gen #(.PRE_DIV(PRE_DIV)) u_tick (
        .clk(clk), .rst(rst), .enable(opt.enable), .src_rc(opt.src_rc),
        .rc_tick(rc_tick), .halted(halted), .clr(count_clr), .tick(tick)
    );

    wdt_clear_ctl u_clr (
        .clk(clk), .rst(rst), .enable(opt.enable), .dual(opt.dual),
        .clr_single(clr_strobe), .clr_a(clr_a_strobe), .clr_b(clr_b_strobe),
        .halt_strobe(halt_strobe), .timeout(timeout),
        .sw_clr(sw_clr), .count_clr(count_clr)
    );

    wdt_counter #(.SHORT_LOG2(SHORT_LOG2), .LONG_LOG2(LONG_LOG2)) u_cnt (
        .clk(clk), .rst(rst), .enable(opt.enable), .long_sel(opt.long_sel),
        .tick(tick), .clr(count_clr), .timeout(timeout)
    );

    wdt_status u_stat (
        .clk(clk), .rst(rst), .timeout(timeout), .halted(halted),
        .sw_clr(sw_clr), .halt_strobe(halt_strobe),
        .chip_req(chip_rst_req), .warm_req(warm_rst_req),
        .to_flag(to_flag), .pdf_flag(pdf_flag)
    );

endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk (
    input logic clk,
    input logic rst,
    input logic opt_enable,
    input logic halted,
    input logic halt_strobe,
    input logic chip_rst_req,
    input logic warm_rst_req,
    input logic to_flag,
    input logic pdf_flag
);
    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(chip_rst_req && warm_rst_req));

    a_r3_chip_one_cycle: assert property (@(posedge clk) disable iff (rst)
        chip_rst_req |=> !chip_rst_req);

    a_r3_warm_one_cycle: assert property (@(posedge clk) disable iff (rst)
        warm_rst_req |=> !warm_rst_req);

    a_r4_warm_from_halt: assert property (@(posedge clk) disable iff (rst)
        warm_rst_req |-> $past(halted));

    a_r4_chip_from_run: assert property (@(posedge clk) disable iff (rst)
        chip_rst_req |-> !$past(halted));

    a_r5_to_with_request: assert property (@(posedge clk) disable iff (rst)
        (chip_rst_req || warm_rst_req) |-> to_flag);

    a_r6_halt_sets_pdf: assert property (@(posedge clk) disable iff (rst)
        halt_strobe |=> (pdf_flag && !to_flag));

    a_r12_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !opt_enable |=> (!chip_rst_req && !warm_rst_req));

endmodule

bind wdt_core wdt_core_chk u_chk (
    .clk(clk), .rst(rst), .opt_enable(opt_enable), .halted(halted),
    .halt_strobe(halt_strobe), .chip_rst_req(chip_rst_req),
    .warm_rst_req(warm_rst_req), .to_flag(to_flag), .pdf_flag(pdf_flag)
);

// File: tb/wdt_core_bench.sv
module wdt_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LO = 4;
    localparam int HI = 5;
    localparam int P_S = 1 << LO;
    localparam int P_L = 1 << HI;
    localparam int K_CHIP = 1;
    localparam int K_WARM = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic opt_enable = 1'b0, opt_src_rc = 1'b1, opt_long = 1'b0, opt_dual = 1'b0;
    logic rc_tick = 1'b0, halted = 1'b0;
    logic clr_strobe = 1'b0, clr_a_strobe = 1'b0, clr_b_strobe = 1'b0, halt_strobe = 1'b0;
    logic chip_rst_req, warm_rst_req, to_flag, pdf_flag;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int    kind;
        int    at;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    wdt_core #(.SHORT_LOG2(LO), .LONG_LOG2(HI)) u_wdt_core (
        .clk(clk), .rst(rst), .opt_enable(opt_enable), .opt_src_rc(opt_src_rc),
        .opt_long(opt_long), .opt_dual(opt_dual), .rc_tick(rc_tick),
        .halted(halted), .clr_strobe(clr_strobe), .clr_a_strobe(clr_a_strobe),
        .clr_b_strobe(clr_b_strobe), .halt_strobe(halt_strobe),
        .chip_rst_req(chip_rst_req), .warm_rst_req(warm_rst_req),
        .to_flag(to_flag), .pdf_flag(pdf_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Driver side of the scoreboard: a request is expected n edges from now
    task automatic expect_req(input int kind, input int n, input string tag);
        exp_t e;
        e.kind = kind;
        e.at   = cyc + n;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic step(input int n, input logic tk);
        for (int i = 0; i < n; i++) begin
            rc_tick = tk;
            @(negedge clk);
        end
        rc_tick = 1'b0;
    endtask

    // 0: clr_strobe, 1: clr_a, 2: clr_b, 3: halt_strobe
    task automatic pulse(input int which);
        case (which)
            0: clr_strobe = 1'b1;
            1: clr_a_strobe = 1'b1;
            2: clr_b_strobe = 1'b1;
            default: halt_strobe = 1'b1;
        endcase
        @(negedge clk);
        clr_strobe = 1'b0; clr_a_strobe = 1'b0; clr_b_strobe = 1'b0; halt_strobe = 1'b0;
    endtask

    // Monitor side of the scoreboard
    always @(negedge clk) begin
        if (!rst && !done && (chip_rst_req || warm_rst_req)) begin
            int kind;
            kind = (chip_rst_req && warm_rst_req) ? 3 : (chip_rst_req ? K_CHIP : K_WARM);
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R3 unexpected request actual=%0d expected=none (cycle %0d)", kind, cyc);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " request kind"}, kind, e.kind);
                chk({e.tag, " request cycle"}, cyc, e.at);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 chip req in reset", chip_rst_req, 0);
        chk("R1 warm req in reset", warm_rst_req, 0);
        chk("R1 to_flag in reset", to_flag, 0);
        chk("R1 pdf_flag in reset", pdf_flag, 0);
        rst = 1'b0;
        opt_enable = 1'b1;

        // R2 R3: oscillator ticks, short period
        expect_req(K_CHIP, P_S, "R3 short");
        step(P_S, 1'b1); step(3, 1'b0);
        chk("R5 to set by timeout", to_flag, 1);

        // R3: long period
        opt_long = 1'b1;
        expect_req(K_CHIP, P_L, "R3 long");
        step(P_L, 1'b1); step(2, 1'b0);
        opt_long = 1'b0;

        // R7: single clear
        step(10, 1'b1); pulse(0);
        chk("R5 to cleared by clear", to_flag, 0);
        step(10, 1'b1);
        expect_req(K_CHIP, 6, "R7 clear restarts");
        step(6, 1'b1); step(2, 1'b0);
        step(10, 1'b1); pulse(1); pulse(2);
        expect_req(K_CHIP, 6, "R7 pair ignored");
        step(6, 1'b1); step(2, 1'b0);

        // R8: dual clear
        opt_dual = 1'b1;
        step(10, 1'b1); pulse(1);
        expect_req(K_CHIP, 6, "R8 single half ignored");
        step(6, 1'b1); step(2, 1'b0);
        step(10, 1'b1); pulse(2); step(3, 1'b1); pulse(1);
        step(10, 1'b1);
        expect_req(K_CHIP, 6, "R8 b then a");
        step(6, 1'b1); step(2, 1'b0);
        // R9: release after completed pair
        step(4, 1'b1); pulse(1); step(2, 1'b1); pulse(2);
        step(5, 1'b1); pulse(2);
        expect_req(K_CHIP, 11, "R9 release on pair");
        step(11, 1'b1); step(2, 1'b0);
        // R9: release after halt
        step(4, 1'b1); pulse(1); pulse(3);
        step(5, 1'b1); pulse(2);
        expect_req(K_CHIP, 11, "R9 release on halt");
        step(11, 1'b1); step(2, 1'b0);
        chk("R6 pdf kept across timeout", pdf_flag, 1);
        pulse(1); pulse(2);
        chk("R6 pdf cleared by pair", pdf_flag, 0);
        step(10, 1'b1); pulse(0);
        expect_req(K_CHIP, 6, "R8 clr_strobe ignored");
        step(6, 1'b1); step(2, 1'b0);
        step(10, 1'b1);
        clr_a_strobe = 1'b1; clr_b_strobe = 1'b1; @(negedge clk);
        clr_a_strobe = 1'b0; clr_b_strobe = 1'b0;
        step(10, 1'b1);
        expect_req(K_CHIP, 6, "R8 same cycle pair");
        step(6, 1'b1); step(2, 1'b0);
        opt_dual = 1'b0;

        // R10 R4: halt clears count, time-out while halted is warm
        step(10, 1'b1); pulse(3);
        chk("R6 pdf set by halt", pdf_flag, 1);
        chk("R5 to cleared by halt", to_flag, 0);
        halted = 1'b1;
        expect_req(K_WARM, P_S, "R4 R10 warm");
        step(P_S, 1'b1); step(2, 1'b0);
        chk("R5 to set by warm timeout", to_flag, 1);
        halted = 1'b0;
        pulse(0);
        chk("R6 pdf cleared by clear", pdf_flag, 0);
        clr_strobe = 1'b1; halt_strobe = 1'b1; @(negedge clk);
        clr_strobe = 1'b0; halt_strobe = 1'b0;
        chk("R6 halt wins over clear", pdf_flag, 1);
        pulse(0);

        // R2 R11: instruction clock source, frozen while halted
        opt_src_rc = 1'b0;
        pulse(0);
        expect_req(K_CHIP, 4 * P_S, "R2 instr clock");
        step(4 * P_S, 1'b1); step(3, 1'b0);
        pulse(3); halted = 1'b1;
        step(200, 1'b0);
        halted = 1'b0;
        expect_req(K_CHIP, 4 * P_S, "R11 frozen in halt");
        step(4 * P_S, 1'b0); step(2, 1'b0);
        pulse(0);
        opt_src_rc = 1'b1;

        // R13: clear and tick in the same cycle
        step(P_S - 1, 1'b1);
        clr_strobe = 1'b1; rc_tick = 1'b1; @(negedge clk);
        clr_strobe = 1'b0; rc_tick = 1'b0;
        expect_req(K_CHIP, P_S, "R13 clear beats tick");
        step(P_S, 1'b1); step(2, 1'b0);

        // R12: disabled
        opt_enable = 1'b0;
        step(40, 1'b1);
        pulse(3);
        chk("R12 halt still sets pdf", pdf_flag, 1);
        pulse(0); pulse(1); pulse(2);
        chk("R12 clear has no effect on pdf", pdf_flag, 1);
        opt_enable = 1'b1;
        expect_req(K_CHIP, P_S, "R12 count held at zero");
        step(P_S, 1'b1); step(2, 1'b0);

        // R1: reset mid-count
        step(10, 1'b1);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk("R1 to after reset", to_flag, 0);
        chk("R1 pdf after reset", pdf_flag, 0);
        expect_req(K_CHIP, P_S, "R1 full period after reset");
        step(P_S, 1'b1); step(3, 1'b0);

        chk("R3 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule